// File: doc/BRIEF.md
# Segmented Stack Push/Pop Unit

This block serves push and pop requests for a 16-bit processor whose call stack lives inside a memory segment. It holds two registers: a stack pointer, which is an offset within the segment, and a segment base. The physical address of the stack top is the segment base shifted left by four bit positions plus the pointer, cut to 20 bits. The stack grows downward. A push lowers the pointer by one word and then stores the word at the new top. A pop reads the word at the top and then raises the pointer by one word.

Memory is reached through a byte-wide synchronous port. Each 16-bit item occupies two byte addresses, with the low byte at the lower one, so every operation makes two back-to-back byte accesses. A requester offers one operation at a time on a valid/ready pair. While an operation is in flight the unit reports busy and holds off new requests. Completion is marked by a single-cycle done pulse, and a popped word is presented at that pulse. Software-visible load strobes let the surrounding core set the segment and the pointer while the unit is idle.

Top module: `segstk_unit`

## Requirements
- R1: `top_addr` equals (`seg_out` × 16 + `sp_out`) modulo 2^20 at all times. For example, segment 1000h with pointer F820h gives 1F820h, and segment FFFFh with pointer 0020h gives 00010h.
- R2: A push is selected by `req_pop`=0. When it is accepted, the pointer drops by 2 on the next clock, and the word is then written at the new top.
- R3: A word is stored little-endian. The low byte goes to the physical address formed from offset `sp`, and the high byte goes to the address formed from offset (`sp`+1) mod 2^16. Pops read back in the same layout.
- R4: A pop is selected by `req_pop`=1. It reads the word at the current top and presents it on `pop_data` in the cycle where `done` is high. The pointer is 2 higher from that cycle on.
- R5: Items come back last-in-first-out: the word pushed most recently is the first one popped.
- R6: Pointer arithmetic wraps modulo 2^16 within the segment, so 0000h minus 2 gives FFFEh. Push and pop never change the segment register.
- R7: Memory is accessed only during an operation. A push makes exactly two byte writes and a pop makes exactly two byte reads. Read data is taken in the cycle after the read strobe.
- R8: `req_ready` is low while the unit is busy or while either load strobe is high, and a request is not taken in such a cycle. Load strobes that arrive while the unit is busy are ignored.
- R9: Each operation yields exactly one `done` pulse lasting one cycle. `busy` is high from the cycle after acceptance: for 2 cycles on a push and for 3 cycles on a pop.
- R10: After reset the pointer and segment are zero, the unit is idle, and `done` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request |
| req_pop | input | 1 | 0 = push, 1 = pop |
| req_wdata | input | 16 | Word to push |
| req_ready | output | 1 | Request is taken this cycle if valid |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| pop_data | output | 16 | Popped word, valid with done |
| seg_load | input | 1 | Load segment register (idle only) |
| seg_in | input | 16 | Segment load value |
| sp_load | input | 1 | Load stack pointer (idle only) |
| sp_in | input | 16 | Pointer load value |
| seg_out | output | 16 | Current segment |
| sp_out | output | 16 | Current stack pointer |
| top_addr | output | 20 | Physical address of stack top |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | 20 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, one cycle after a read strobe |

## Verification
The bench builds the unit with its default parameters: a 16-bit pointer and segment, a shift of four, and byte lanes of 8 bits. This gives the 20-bit physical space the requirements describe. With these values it can reach the pointer wrap at offset zero, an odd pointer whose high byte wraps to offset zero, and a segment base near the top of memory whose sum overflows 20 bits. It also checks the stalls caused by load strobes and by busy cycles.

// File: rtl/segstk_pkg.sv
package segstk_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WLO,
      ST_WHI,
      ST_RLO,
      ST_RHI,
      ST_REND
   } segstk_st_e;
endpackage

// File: rtl/segstk_agen.sv
module segstk_agen #(
   parameter int SEG_W     = 16,
   parameter int PTR_W     = 16,
   parameter int SEG_SHIFT = 4,
   localparam int ADDR_W   = SEG_W + SEG_SHIFT
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [PTR_W-1:0]  ptr,
   input  logic              hi_sel,
   output logic [ADDR_W-1:0] phys
);
   logic [PTR_W-1:0] off;
   assign off = ptr + PTR_W'(hi_sel);

   generate
      if (SEG_SHIFT == 0) begin : g_flat
         assign phys = ADDR_W'(seg) + ADDR_W'(off);
      end else begin : g_shift
         assign phys = {seg, {SEG_SHIFT{1'b0}}} + ADDR_W'(off);
      end
   endgenerate
endmodule

// File: rtl/segstk_fsm.sv
module segstk_fsm
   import segstk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       op_pop,
   output segstk_st_e st,
   output logic       done
);
   segstk_st_e st_nx;

   always_comb begin
      st_nx = st;
      case (st)
         ST_IDLE: if (start) st_nx = op_pop ? ST_RLO : ST_WLO;
         ST_WLO:  st_nx = ST_WHI;
         ST_WHI:  st_nx = ST_IDLE;
         ST_RLO:  st_nx = ST_RHI;
         ST_RHI:  st_nx = ST_REND;
         ST_REND: st_nx = ST_IDLE;
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         done <= 1'b0;
      end else begin
         st   <= st_nx;
         done <= (st == ST_WHI) || (st == ST_REND);
      end
   end
endmodule

// File: rtl/segstk_unit.sv
module segstk_unit
   import segstk_pkg::*;
#(
   parameter int SEG_W     = 16,
   parameter int PTR_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int BYTE_W    = 8,
   localparam int DATA_W   = 2 * BYTE_W,
   localparam int ADDR_W   = SEG_W + SEG_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_pop,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] pop_data,
   input  logic              seg_load,
   input  logic [SEG_W-1:0]  seg_in,
   input  logic              sp_load,
   input  logic [PTR_W-1:0]  sp_in,
   output logic [SEG_W-1:0]  seg_out,
   output logic [PTR_W-1:0]  sp_out,
   output logic [ADDR_W-1:0] top_addr,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata
);
   localparam logic [PTR_W-1:0] STEP = PTR_W'(DATA_W / BYTE_W);

   generate
      if (PTR_W > ADDR_W) begin : g_bad_ptr
         $error("segstk_unit: PTR_W must not exceed SEG_W+SEG_SHIFT");
      end
      if (SEG_SHIFT < 0) begin : g_bad_shift
         $error("segstk_unit: SEG_SHIFT must be non-negative");
      end
      if (BYTE_W < 1) begin : g_bad_byte
         $error("segstk_unit: BYTE_W must be positive");
      end
   endgenerate

   segstk_st_e        st;
   logic [PTR_W-1:0]  sp_q;
   logic [SEG_W-1:0]  seg_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rd_q;
   logic              accept;
   logic              hi_sel;

   assign busy      = (st != ST_IDLE);
   assign req_ready = !busy && !seg_load && !sp_load;
   assign accept    = req_valid && req_ready;

   segstk_fsm u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .op_pop (req_pop),
      .st     (st),
      .done   (done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q    <= '0;
         seg_q   <= '0;
         wdata_q <= '0;
         rd_q    <= '0;
      end else begin
         if (!busy) begin
            if (seg_load) seg_q <= seg_in;
            if (sp_load)  sp_q  <= sp_in;
            if (accept && !req_pop) begin
               sp_q    <= sp_q - STEP;
               wdata_q <= req_wdata;
            end
         end
         case (st)
            ST_RHI:  rd_q[BYTE_W-1:0] <= mem_rdata;
            ST_REND: begin
               rd_q[DATA_W-1:BYTE_W] <= mem_rdata;
               sp_q                  <= sp_q + STEP;
            end
            default: ;
         endcase
      end
   end

   assign mem_en    = (st == ST_WLO) || (st == ST_WHI) || (st == ST_RLO) || (st == ST_RHI);
   assign mem_we    = (st == ST_WLO) || (st == ST_WHI);
   assign hi_sel    = (st == ST_WHI) || (st == ST_RHI);
   assign mem_wdata = hi_sel ? wdata_q[DATA_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];

   segstk_agen #(.SEG_W(SEG_W), .PTR_W(PTR_W), .SEG_SHIFT(SEG_SHIFT)) u_agen_top (
      .seg    (seg_q),
      .ptr    (sp_q),
      .hi_sel (1'b0),
      .phys   (top_addr)
   );

   segstk_agen #(.SEG_W(SEG_W), .PTR_W(PTR_W), .SEG_SHIFT(SEG_SHIFT)) u_agen_mem (
      .seg    (seg_q),
      .ptr    (sp_q),
      .hi_sel (hi_sel),
      .phys   (mem_addr)
   );

   assign seg_out  = seg_q;
   assign sp_out   = sp_q;
   assign pop_data = rd_q;
endmodule

// File: rtl/segstk_chk.sv
module segstk_chk #(
   parameter int SEG_W = 16,
   parameter int PTR_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_pop,
   input logic             req_ready,
   input logic             busy,
   input logic             done,
   input logic             mem_en,
   input logic [SEG_W-1:0] seg_out,
   input logic [PTR_W-1:0] sp_out
);
   assert_idle_no_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_en);

   assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ready);

   assert_seg_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(seg_out));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_pop) |=> (sp_out == $past(sp_out) - PTR_W'(2)));

   assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> busy);
endmodule

bind segstk_unit segstk_chk #(.SEG_W(SEG_W), .PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_pop   (req_pop),
   .req_ready (req_ready),
   .busy      (busy),
   .done      (done),
   .mem_en    (mem_en),
   .seg_out   (seg_out),
   .sp_out    (sp_out)
);

// File: tb/segstk_unit_tb.sv
module segstk_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_pop = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        req_ready, busy, done;
   logic [15:0] pop_data;
   logic        seg_load = 1'b0;
   logic [15:0] seg_in = '0;
   logic        sp_load = 1'b0;
   logic [15:0] sp_in = '0;
   logic [15:0] seg_out, sp_out;
   logic [19:0] top_addr;
   logic        mem_en, mem_we;
   logic [19:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   int done_cnt = 0;
   int op_cnt = 0;
   int wr_cnt = 0;
   int rd_cnt = 0;
   bit pop_pending = 1'b0;
   bit finished = 1'b0;
   logic [15:0] exp_q[$];
   logic [7:0]  mem [logic [19:0]];

   always #(CLK_PERIOD/2) clk = ~clk;

   segstk_unit u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pop(req_pop),
      .req_wdata(req_wdata), .req_ready(req_ready), .busy(busy), .done(done),
      .pop_data(pop_data), .seg_load(seg_load), .seg_in(seg_in),
      .sp_load(sp_load), .sp_in(sp_in), .seg_out(seg_out), .sp_out(sp_out),
      .top_addr(top_addr), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_cnt++;
         end else begin
            mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
            rd_cnt++;
         end
      end
   end

   function automatic logic [7:0] peek(input logic [19:0] a);
      return mem.exists(a) ? mem[a] : 8'h00;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: compares popped words against the queue
   always @(negedge clk) begin
      if (done) done_cnt++;
      if (done && pop_pending) begin
         if (exp_q.size() == 0) check("R5 empty queue", 32'd1, 32'd0);
         else check("R4 R5 pop order/data", {16'h0, pop_data}, {16'h0, exp_q.pop_front()});
      end
   end

   task automatic issue(input bit pop, input logic [15:0] d, input bit disturb);
      @(negedge clk);
      req_valid = 1'b1;
      req_pop   = pop;
      req_wdata = d;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      op_cnt++;
      if (pop) pop_pending = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (disturb) begin
         seg_load = 1'b1; seg_in = 16'hDEAD;
         sp_load  = 1'b1; sp_in  = 16'hBEEF;
         #1;
         check("R8 ready low while busy", {31'h0, req_ready}, 32'd0);
      end
      while (!done) @(negedge clk);
      seg_load = 1'b0;
      sp_load  = 1'b0;
      @(posedge clk);
      pop_pending = 1'b0;
   endtask

   task automatic load(input logic [15:0] s, input logic [15:0] p);
      @(negedge clk);
      seg_load = 1'b1; seg_in = s;
      sp_load  = 1'b1; sp_in  = p;
      @(negedge clk);
      seg_load = 1'b0; sp_load = 1'b0;
   endtask

   task automatic push_w(input logic [15:0] d);
      issue(1'b0, d, 1'b0);
   endtask

   task automatic pop_w(input logic [15:0] e);
      exp_q.push_back(e);
      issue(1'b1, 16'h0, 1'b0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      check("watchdog expired", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      int cyc;
      int w0, r0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10 reset state
      check("R10 sp after reset", {16'h0, sp_out}, 32'h0);
      check("R10 seg after reset", {16'h0, seg_out}, 32'h0);
      check("R10 idle/done/mem_en", {29'h0, busy, done, mem_en}, 32'h0);
      rst_n = 1'b1;

      // R1 address formation
      load(16'h1000, 16'hF820);
      check("R1 top_addr 1000:F820", {12'h0, top_addr}, 32'h1F820);

      // R2 R3 push
      w0 = wr_cnt;
      push_w(16'h1234);
      check("R2 sp after push", {16'h0, sp_out}, 32'hF81E);
      check("R3 low byte", {24'h0, peek(20'h1F81E)}, 32'h34);
      check("R3 high byte", {24'h0, peek(20'h1F81F)}, 32'h12);
      check("R7 two writes per push", wr_cnt - w0, 32'd2);
      check("R6 seg kept on push", {16'h0, seg_out}, 32'h1000);
      push_w(16'h5678);
      // R5 LIFO order through scoreboard
      r0 = rd_cnt;
      pop_w(16'h5678);
      check("R7 two reads per pop", rd_cnt - r0, 32'd2);
      pop_w(16'h1234);
      check("R4 sp after pops", {16'h0, sp_out}, 32'hF820);

      // R6 pointer wrap at offset zero
      load(16'h1000, 16'h0000);
      push_w(16'hBEEF);
      check("R6 sp wraps to FFFE", {16'h0, sp_out}, 32'hFFFE);
      check("R6 wrapped write addr", {24'h0, peek(20'h1FFFE)}, 32'hEF);
      pop_w(16'hBEEF);
      check("R6 sp wraps back to 0", {16'h0, sp_out}, 32'h0);

      // R3 odd pointer, high byte offset wraps to 0
      mem[20'h1FFFF] = 8'h5A;
      mem[20'h10000] = 8'hC3;
      load(16'h1000, 16'hFFFF);
      pop_w(16'hC35A);
      check("R6 sp FFFF+2", {16'h0, sp_out}, 32'h0001);
      check("R6 seg kept on pop", {16'h0, seg_out}, 32'h1000);

      // R1 physical overflow past 20 bits
      load(16'hFFFF, 16'h0020);
      check("R1 top_addr FFFF:0020", {12'h0, top_addr}, 32'h00010);
      push_w(16'h0A0B);
      check("R1 wrapped phys write", {24'h0, peek(20'h0000E)}, 32'h0B);

      // R8 load strobe stalls a request; loads ignored while busy
      load(16'h2000, 16'h0100);
      @(negedge clk);
      sp_load = 1'b1; sp_in = 16'h0300;
      req_valid = 1'b1; req_pop = 1'b0;
      #1;
      check("R8 ready low with load", {31'h0, req_ready}, 32'd0);
      @(negedge clk);
      sp_load = 1'b0; req_valid = 1'b0;
      check("R8 no accept with load", {31'h0, busy}, 32'd0);
      check("R8 idle load applied", {16'h0, sp_out}, 32'h0300);
      issue(1'b0, 16'h7777, 1'b1);
      check("R8 sp load ignored while busy", {16'h0, sp_out}, 32'h02FE);
      check("R8 seg load ignored while busy", {16'h0, seg_out}, 32'h2000);

      // R9 busy lengths
      @(negedge clk);
      req_valid = 1'b1; req_pop = 1'b1;
      exp_q.push_back(16'h7777);
      @(posedge clk);
      op_cnt++;
      pop_pending = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 0;
      while (busy) begin
         cyc++;
         @(negedge clk);
      end
      check("R9 pop busy cycles", cyc, 32'd3);
      check("R9 done after pop", {31'h0, done}, 32'd1);
      @(posedge clk);
      pop_pending = 1'b0;
      @(negedge clk);
      check("R9 done count", done_cnt, op_cnt);
      check("R5 queue drained", exp_q.size(), 32'd0);
      finish_run();
   end
endmodule